// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block is the requesting side of an indirect register path. Another agent on the chip holds a small mailbox with two 32-bit registers: an interface register, where a command opcode is launched and a completion code returned, and a data register, which carries the argument of each command and any value read back. A client asks for one CSR-space or MMIO-space read or write, or for a read-modify-write, and the sequencer turns that single request into a chain of mailbox commands. Each command writes its argument and launches the opcode, then polls for completion at a fixed interval, checks the completion code and retries if needed.

A transaction always has four commands. An open command carries a sequence ID. A register command carries the target address. A data command carries the write data, or zero for a read. The data register is captured after the data command. A close command repeats the sequence ID. A command that never succeeds is abandoned after a bounded number of attempts. The transaction then continues and reports an error at the end. An update request runs a complete read transaction, merges the value with an AND mask and an OR mask, and then runs a complete write transaction to the same address.

The request side is a valid/ready handshake. The block takes one request at a time and holds `req_ready` low from acceptance until the response has been given. The client must keep the request fields stable while `req_valid` is high and `req_ready` is low. There is no back-pressure on the response: `rsp_done` pulses for one cycle, and `rsp_rdata` and `rsp_err` stay valid from that cycle until the next request is accepted. The mailbox bus is a plain single-cycle register port, and read data returns in the same cycle as the request.

Top module: `mbox_sequencer`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, and `mb_req`, `rsp_done`, `rsp_err` and `rsp_rdata` are 0.
- R2: A read runs, in this order: open (opcode 0x02) with ID 1 for CSR or 3 for MMIO; the register opcode (0x13 CSR, 0x15 MMIO) with the address; read-data (0x07) with data 0; close (0x03) with the same ID. `rsp_rdata` is the data register value read after the read-data command.
- R3: Every command first writes its argument to the data register at address 0x6C04. In the next cycle it writes the interface register at 0x6C00 with the opcode in bits 7:0 and the run bit 31 set.
- R4: A write runs open with ID 2 for CSR or 4 for MMIO, the register opcode (0x14 CSR, 0x16 MMIO) with the address, write-data (0x08) with the request's write data, and close with the same ID. `rsp_rdata` is 0.
- R5: After launching a command, the block reads the interface register until bit 31 is clear, at most POLL_LIMIT times per attempt. If bit 31 first reads clear on the last allowed poll, the attempt completes without a retry. If all POLL_LIMIT polls read busy, the command starts a new attempt.
- R6: Successive polls within one attempt are exactly CLK_MHZ*POLL_GAP_US+1 clock cycles apart.
- R7: A completed command succeeds only if the low 16 bits of the interface register are 0x0040. Any other code (for example 0x0080, 0x0082 or 0x0090) starts a new attempt, which begins again with the data register write.
- R8: After RETRY_LIMIT failed attempts the command is abandoned and the error is recorded. The remaining commands of the transaction are still sent, and `rsp_err` is 1 for that request.
- R9: An update runs a full read transaction and then a full write transaction of the same space and address, with write data (old & and_mask) | or_mask. `rsp_rdata` returns the old value.
- R10: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the cycle after `rsp_done`. `rsp_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_mmio | input | 1 | 1 = MMIO space, 0 = CSR space |
| req_write | input | 1 | 1 = write, 0 = read (ignored when req_update is 1) |
| req_update | input | 1 | Read-modify-write request |
| req_addr | input | 32 | Target address |
| req_wdata | input | 32 | Write data |
| req_and_mask | input | 32 | AND mask for an update |
| req_or_mask | input | 32 | OR mask for an update |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read value (old value for an update) |
| rsp_err | output | 1 | At least one command was abandoned |
| mb_req | output | 1 | Mailbox register access strobe |
| mb_we | output | 1 | 1 = write, 0 = read |
| mb_addr | output | 16 | Mailbox register address |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, same cycle as mb_req |

## Verification
The assertions check, on every cycle, the ordering and spacing rules of the mailbox port. An interface register launch always follows a data register write in the cycle before. Two polls never fall in adjacent cycles. The attempt and poll counters stay within their limits. On the request side, `rsp_done` is a single pulse, and `req_ready` falls right after acceptance. Only the bench scenarios can show the opcodes, IDs and arguments of the four-command chain, the exact poll interval, the point where a busy or rejected command is retried or abandoned, the continuation after an abandoned command, and the merged value an update writes back. The bench checks these against a mailbox model whose busy length and completion codes it sets per command.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

  typedef enum logic [7:0] {
    OP_OPEN    = 8'h02,
    OP_CLOSE   = 8'h03,
    OP_RD_DATA = 8'h07,
    OP_WR_DATA = 8'h08,
    OP_RD_CSR  = 8'h13,
    OP_WR_CSR  = 8'h14,
    OP_RD_MMIO = 8'h15,
    OP_WR_MMIO = 8'h16
  } mbox_op_e;

  typedef enum logic [2:0] {
    STEP_OPEN,
    STEP_REGA,
    STEP_DATA,
    STEP_CAPT,
    STEP_CLOSE
  } mbox_step_e;

  localparam logic [15:0] MBOX_RESP_OK = 16'h0040;
  localparam int          MBOX_RUN_BIT = 31;

  // Sequence ID: 1 rd csr, 2 wr csr, 3 rd mmio, 4 wr mmio
  function automatic logic [31:0] seq_code(input logic mmio, input logic wr);
    logic [2:0] v;
    v = {1'b0, mmio, 1'b0} + {2'b0, wr} + 3'd1;
    return {29'b0, v};
  endfunction

  function automatic mbox_op_e reg_opcode(input logic mmio, input logic wr);
    case ({mmio, wr})
      2'b00:   return OP_RD_CSR;
      2'b01:   return OP_WR_CSR;
      2'b10:   return OP_RD_MMIO;
      default: return OP_WR_MMIO;
    endcase
  endfunction

endpackage

// File: rtl/mbox_gap_timer.sv
module mbox_gap_timer #(
  parameter int GAP_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(GAP_CYC - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
  import mbox_seq_pkg::*;
#(
  parameter int             AW          = 16,
  parameter int             DW          = 32,
  parameter logic [AW-1:0]  IF_ADDR     = 16'h6C00,
  parameter logic [AW-1:0]  DATA_ADDR   = 16'h6C04,
  parameter int             POLL_LIMIT  = 100,
  parameter int             RETRY_LIMIT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          capture,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] cmd_data,
  output logic          done,
  output logic          fail,
  output logic [DW-1:0] cap_data,
  output logic          gap_load,
  input  logic          gap_expired,
  output logic          mb_req,
  output logic          mb_we,
  output logic [AW-1:0] mb_addr,
  output logic [DW-1:0] mb_wdata,
  input  logic [DW-1:0] mb_rdata
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int RW = $clog2(RETRY_LIMIT + 1);

  typedef enum logic [2:0] {
    E_IDLE, E_WDAT, E_WIF, E_POLL, E_WAIT, E_CAPT, E_FIN
  } eng_state_e;

  eng_state_e    state;
  logic [7:0]    op_q;
  logic [DW-1:0] data_q;
  logic [PW-1:0] poll_q;
  logic [RW-1:0] attempt_q;
  logic          fail_q;
  logic [DW-1:0] cap_q;

  logic run_busy, resp_ok, last_poll, last_try;
  assign run_busy  = mb_rdata[MBOX_RUN_BIT];
  assign resp_ok   = (mb_rdata[15:0] == MBOX_RESP_OK);
  assign last_poll = (poll_q == PW'(POLL_LIMIT - 1));
  assign last_try  = (attempt_q == RW'(RETRY_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= E_IDLE;
      op_q      <= '0;
      data_q    <= '0;
      poll_q    <= '0;
      attempt_q <= '0;
      fail_q    <= 1'b0;
      cap_q     <= '0;
    end else begin
      case (state)
        E_IDLE: if (start) begin
          op_q      <= opcode;
          data_q    <= cmd_data;
          attempt_q <= '0;
          fail_q    <= 1'b0;
          state     <= capture ? E_CAPT : E_WDAT;
        end
        E_WDAT: state <= E_WIF;
        E_WIF: begin
          poll_q <= '0;
          state  <= E_POLL;
        end
        E_POLL: begin
          if (!run_busy && resp_ok) begin
            state <= E_FIN;
          end else if (run_busy && !last_poll) begin
            poll_q <= poll_q + 1'b1;
            state  <= E_WAIT;
          end else if (last_try) begin
            fail_q <= 1'b1;
            state  <= E_FIN;
          end else begin
            attempt_q <= attempt_q + 1'b1;
            state     <= E_WDAT;
          end
        end
        E_WAIT: if (gap_expired) state <= E_POLL;
        E_CAPT: begin
          cap_q <= mb_rdata;
          state <= E_FIN;
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    mb_req   = 1'b0;
    mb_we    = 1'b0;
    mb_addr  = DATA_ADDR;
    mb_wdata = '0;
    case (state)
      E_WDAT: begin
        mb_req   = 1'b1;
        mb_we    = 1'b1;
        mb_wdata = data_q;
      end
      E_WIF: begin
        mb_req   = 1'b1;
        mb_we    = 1'b1;
        mb_addr  = IF_ADDR;
        mb_wdata = DW'(op_q);
        mb_wdata[MBOX_RUN_BIT] = 1'b1;
      end
      E_POLL: begin
        mb_req  = 1'b1;
        mb_addr = IF_ADDR;
      end
      E_CAPT: mb_req = 1'b1;
      default: ;
    endcase
  end

  assign gap_load = (state == E_POLL) && run_busy && !last_poll;
  assign done     = (state == E_FIN);
  assign fail     = fail_q;
  assign cap_data = cap_q;

  AST_LAUNCH_AFTER_ARG: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && mb_we && mb_addr == IF_ADDR) |->
      $past(mb_req && mb_we && mb_addr == DATA_ADDR)) else $error("launch without argument"); // R3

  AST_POLL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && !mb_we && mb_addr == IF_ADDR) |=>
      !(mb_req && !mb_we && mb_addr == IF_ADDR)) else $error("back-to-back polls"); // R6

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(poll_q) < POLL_LIMIT) else $error("poll count overrun"); // R5

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(attempt_q) < RETRY_LIMIT) else $error("attempt count overrun"); // R8
endmodule

// File: rtl/mbox_sequencer.sv
module mbox_sequencer
  import mbox_seq_pkg::*;
#(
  parameter int             AW          = 16,
  parameter int             DW          = 32,
  parameter logic [AW-1:0]  IF_ADDR     = 16'h6C00,
  parameter logic [AW-1:0]  DATA_ADDR   = 16'h6C04,
  parameter int             CLK_MHZ     = 125,
  parameter int             POLL_GAP_US = 10,
  parameter int             POLL_LIMIT  = 100,
  parameter int             RETRY_LIMIT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_mmio,
  input  logic          req_write,
  input  logic          req_update,
  input  logic [31:0]   req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_and_mask,
  input  logic [DW-1:0] req_or_mask,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          mb_req,
  output logic          mb_we,
  output logic [AW-1:0] mb_addr,
  output logic [DW-1:0] mb_wdata,
  input  logic [DW-1:0] mb_rdata
);
  localparam int GAP_CYC = CLK_MHZ * POLL_GAP_US;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} seq_state_e;

  seq_state_e    state;
  mbox_step_e    step;
  logic          mmio_q, write_q, upd_q, err_q;
  logic [31:0]   addr_q;
  logic [DW-1:0] wdata_q, and_q, or_q, rd_q;

  logic          cmd_start, cmd_capture, cmd_done, cmd_fail;
  logic [7:0]    cmd_op;
  logic [DW-1:0] cmd_data, cap_data;
  logic          gap_load, gap_expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      step    <= STEP_OPEN;
      mmio_q  <= 1'b0;
      write_q <= 1'b0;
      upd_q   <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      and_q   <= '0;
      or_q    <= '0;
      rd_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          mmio_q  <= req_mmio;
          write_q <= req_write && !req_update;
          upd_q   <= req_update;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          and_q   <= req_and_mask;
          or_q    <= req_or_mask;
          err_q   <= 1'b0;
          rd_q    <= '0;
          step    <= STEP_OPEN;
          state   <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (cmd_done) begin
          err_q <= err_q | cmd_fail;
          if (step == STEP_CAPT && !write_q) rd_q <= cap_data;
          if (step == STEP_CLOSE) begin
            if (upd_q && !write_q) begin
              write_q <= 1'b1;
              wdata_q <= (rd_q & and_q) | or_q;
              step    <= STEP_OPEN;
              state   <= S_ISSUE;
            end else begin
              state <= S_RESP;
            end
          end else begin
            step  <= mbox_step_e'(step + 3'd1);
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_capture = 1'b0;
    cmd_op      = OP_OPEN;
    cmd_data    = seq_code(mmio_q, write_q);
    case (step)
      STEP_REGA: begin
        cmd_op   = reg_opcode(mmio_q, write_q);
        cmd_data = addr_q;
      end
      STEP_DATA: begin
        cmd_op   = write_q ? OP_WR_DATA : OP_RD_DATA;
        cmd_data = write_q ? wdata_q : '0;
      end
      STEP_CAPT:  cmd_capture = 1'b1;
      STEP_CLOSE: cmd_op = OP_CLOSE;
      default: ;
    endcase
  end

  assign cmd_start = (state == S_ISSUE);
  assign req_ready = (state == S_IDLE);
  assign rsp_done  = (state == S_RESP);
  assign rsp_rdata = rd_q;
  assign rsp_err   = err_q;

  mbox_cmd_engine #(
    .AW(AW), .DW(DW), .IF_ADDR(IF_ADDR), .DATA_ADDR(DATA_ADDR),
    .POLL_LIMIT(POLL_LIMIT), .RETRY_LIMIT(RETRY_LIMIT)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_start), .capture(cmd_capture), .opcode(cmd_op), .cmd_data(cmd_data),
    .done(cmd_done), .fail(cmd_fail), .cap_data(cap_data),
    .gap_load(gap_load), .gap_expired(gap_expired),
    .mb_req(mb_req), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_rdata(mb_rdata)
  );

  generate
    if (GAP_CYC > 0) begin : g_timer
      mbox_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_expired)
      );
    end else begin : g_no_timer
      assign gap_expired = 1'b1;
    end
  endgenerate

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done) else $error("done longer than a cycle"); // R10

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("ready after accept"); // R10

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready) else $error("not idle after done"); // R10

  AST_NO_BUS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> !mb_req) else $error("bus active while idle"); // R1
endmodule

// File: tb/mbox_sequencer_tb.sv
`timescale 1ns/1ps
module mbox_sequencer_tb;
  localparam int PL  = 6;
  localparam int RL  = 3;
  localparam int GAP = 4;
  localparam logic [15:0] IFA = 16'h6C00;
  localparam logic [15:0] DTA = 16'h6C04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_mmio = 1'b0, req_write = 1'b0, req_update = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, req_and_mask = '0, req_or_mask = '0;
  logic        req_ready, rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mb_req, mb_we;
  logic [15:0] mb_addr;
  logic [31:0] mb_wdata, mb_rdata;

  mbox_sequencer #(.CLK_MHZ(1), .POLL_GAP_US(GAP), .POLL_LIMIT(PL), .RETRY_LIMIT(RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mmio(req_mmio), .req_write(req_write), .req_update(req_update),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_and_mask(req_and_mask),
    .req_or_mask(req_or_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mb_req(mb_req), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  // ---------------- mailbox target model ----------------
  int          busy_cfg = 0, busy_until = 0, fail_until = 0;
  logic [15:0] fail_code = 16'h0090;

  logic [7:0]  log_op  [0:255];
  logic [31:0] log_dat [0:255];
  logic        log_run [0:255];
  int          log_n, busy_left, gap_n, gap_bad, dat_wr_n;
  longint      cyc, last_rd;
  logic [31:0] dat_reg, mem_csr, mem_mmio;
  logic [15:0] resp_code;
  logic [7:0]  cur_op;
  logic        last_mmio, first_poll;

  always @(posedge clk) begin
    if (!rst_n) begin
      log_n <= 0; busy_left <= 0; gap_n <= 0; gap_bad <= 0; dat_wr_n <= 0;
      cyc <= 0; last_rd <= 0; dat_reg <= '0; mem_csr <= 32'h1357_2468;
      mem_mmio <= 32'h0BAD_F00D; resp_code <= 16'h0040; cur_op <= '0;
      last_mmio <= 1'b0; first_poll <= 1'b1;
    end else begin
      cyc <= cyc + 1;
      if (mb_req && mb_we && mb_addr == DTA) begin
        dat_reg  <= mb_wdata;
        dat_wr_n <= dat_wr_n + 1;
      end
      if (mb_req && mb_we && mb_addr == IFA) begin
        log_op[log_n[7:0]]  <= mb_wdata[7:0];
        log_dat[log_n[7:0]] <= dat_reg;
        log_run[log_n[7:0]] <= mb_wdata[31];
        log_n      <= log_n + 1;
        busy_left  <= (log_n < busy_until) ? busy_cfg : 0;
        resp_code  <= (log_n < fail_until) ? fail_code : 16'h0040;
        cur_op     <= mb_wdata[7:0];
        first_poll <= 1'b1;
        case (mb_wdata[7:0])
          8'h13, 8'h14: last_mmio <= 1'b0;
          8'h15, 8'h16: last_mmio <= 1'b1;
          8'h07: dat_reg <= last_mmio ? mem_mmio : mem_csr;
          8'h08: if (last_mmio) mem_mmio <= dat_reg; else mem_csr <= dat_reg;
          default: ;
        endcase
      end
      if (mb_req && !mb_we && mb_addr == IFA) begin
        if (busy_left > 0) busy_left <= busy_left - 1;
        if (!first_poll) begin
          gap_n <= gap_n + 1;
          if (cyc - last_rd != longint'(GAP + 1)) gap_bad <= gap_bad + 1;
        end
        first_poll <= 1'b0;
        last_rd    <= cyc;
      end
    end
  end

  assign mb_rdata = (mb_addr == IFA) ?
                    ((busy_left > 0) ? {1'b1, 23'b0, cur_op} : {16'h0, resp_code}) : dat_reg;

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  logic [31:0] got_rdata;
  logic        got_err;
  logic        finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_entry(input string tag, input int idx, input logic [7:0] op, input logic [31:0] dat);
    chk({tag, " opcode"}, {24'h0, log_op[idx[7:0]]}, {24'h0, op});
    chk({tag, " argument"}, log_dat[idx[7:0]], dat);
  endtask

  task automatic do_req(input logic mmio, input logic wr, input logic upd, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [31:0] am, input logic [31:0] om);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_mmio = mmio; req_write = wr; req_update = upd;
    req_addr = addr; req_wdata = wd; req_and_mask = am; req_or_mask = om;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 ready low after accept", {31'b0, req_ready}, 32'd0);
    guard = 0;
    while (!rsp_done && guard < 30000) begin
      @(negedge clk);
      guard++;
    end
    chk("R10 done seen", {31'b0, rsp_done}, 32'd1);
    got_rdata = rsp_rdata;
    got_err   = rsp_err;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R1 bus idle in reset", {31'b0, mb_req}, 32'd0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1 done low", {31'b0, rsp_done}, 32'd0);
    chk("R1 err low", {31'b0, rsp_err}, 32'd0);
    chk("R1 rdata zero", rsp_rdata, 32'd0);
    chk("R1 bus idle", {31'b0, mb_req}, 32'd0);
  endtask

  task automatic t_read_csr;
    int b, dw;
    b = log_n; dw = dat_wr_n;
    do_req(1'b0, 1'b0, 1'b0, 32'h0000_1A2B, 32'hFFFF_FFFF, '0, '0);
    chk("R2 command count", log_n - b, 4);
    chk_entry("R2 open", b, 8'h02, 32'd1);
    chk_entry("R2 reg", b + 1, 8'h13, 32'h0000_1A2B);
    chk_entry("R2 data", b + 2, 8'h07, 32'd0);
    chk_entry("R2 close", b + 3, 8'h03, 32'd1);
    chk("R2 rdata", got_rdata, 32'h1357_2468);
    chk("R2 err", {31'b0, got_err}, 32'd0);
    chk("R3 one argument write per command", dat_wr_n - dw, 4);
    for (int i = 0; i < 4; i++) chk("R3 run bit set", {31'b0, log_run[(b + i) & 255]}, 32'd1);
  endtask

  task automatic t_write_mmio;
    int b;
    b = log_n;
    do_req(1'b1, 1'b1, 1'b0, 32'h00C0_FFEE, 32'hA5A5_0F0F, '0, '0);
    chk("R4 command count", log_n - b, 4);
    chk_entry("R4 open", b, 8'h02, 32'd4);
    chk_entry("R4 reg", b + 1, 8'h16, 32'h00C0_FFEE);
    chk_entry("R4 data", b + 2, 8'h08, 32'hA5A5_0F0F);
    chk_entry("R4 close", b + 3, 8'h03, 32'd4);
    chk("R4 target updated", mem_mmio, 32'hA5A5_0F0F);
    chk("R4 rdata zero", got_rdata, 32'd0);
    b = log_n;
    do_req(1'b1, 1'b0, 1'b0, 32'h00C0_FFEE, '0, '0, '0);
    chk_entry("R2 mmio open", b, 8'h02, 32'd3);
    chk_entry("R2 mmio reg", b + 1, 8'h15, 32'h00C0_FFEE);
    chk("R2 mmio rdata", got_rdata, 32'hA5A5_0F0F);
    b = log_n;
    do_req(1'b0, 1'b1, 1'b0, 32'h0000_0040, 32'h7777_0001, '0, '0);
    chk_entry("R4 csr open", b, 8'h02, 32'd2);
    chk_entry("R4 csr reg", b + 1, 8'h14, 32'h0000_0040);
    chk("R4 csr target", mem_csr, 32'h7777_0001);
  endtask

  task automatic t_busy_in_limit;
    int b, gn, gb;
    b = log_n; gn = gap_n; gb = gap_bad;
    @(negedge clk); busy_cfg = PL - 1; busy_until = log_n + 4;
    do_req(1'b0, 1'b0, 1'b0, 32'h10, '0, '0, '0);
    chk("R5 no retry at last poll", log_n - b, 4);
    chk("R5 err clear", {31'b0, got_err}, 32'd0);
    chk("R6 spaced polls seen", gap_n - gn, 4 * (PL - 1));
    chk("R6 poll spacing", gap_bad - gb, 0);
  endtask

  task automatic t_busy_timeout;
    int b;
    b = log_n;
    @(negedge clk); busy_cfg = PL; busy_until = log_n + 1;
    do_req(1'b0, 1'b0, 1'b0, 32'h20, '0, '0, '0);
    chk("R5 timeout retried once", log_n - b, 5);
    chk_entry("R5 retry repeats open", b + 1, 8'h02, 32'd1);
    chk("R5 retry recovers", {31'b0, got_err}, 32'd0);
    busy_until = 0;
  endtask

  task automatic t_reject_retry;
    int b;
    b = log_n;
    @(negedge clk); fail_code = 16'h0080; fail_until = log_n + 2;
    do_req(1'b0, 1'b0, 1'b0, 32'h30, '0, '0, '0);
    chk("R7 rejected twice then ok", log_n - b, 6);
    chk_entry("R7 third open", b + 2, 8'h02, 32'd1);
    chk("R7 no error", {31'b0, got_err}, 32'd0);
    b = log_n;
    @(negedge clk); fail_code = 16'h0082; fail_until = log_n + 3;
    do_req(1'b1, 1'b0, 1'b0, 32'h34, '0, '0, '0);
    chk("R7 thread-unavailable retried", log_n - b, 6);
    chk_entry("R7 reg after retries", b + 3, 8'h15, 32'h34);
  endtask

  task automatic t_reject_all;
    int b;
    b = log_n;
    @(negedge clk); fail_code = 16'h0090; fail_until = log_n + 1000;
    do_req(1'b0, 1'b1, 1'b0, 32'h44, 32'h1234_5678, '0, '0);
    chk("R8 every command tried RETRY_LIMIT times", log_n - b, 4 * RL);
    chk_entry("R8 reg still sent", b + RL, 8'h14, 32'h44);
    chk_entry("R8 data still sent", b + 2 * RL, 8'h08, 32'h1234_5678);
    chk_entry("R8 close still sent", b + 4 * RL - 1, 8'h03, 32'd2);
    chk("R8 error flagged", {31'b0, got_err}, 32'd1);
    @(negedge clk); fail_until = 0;
    do_req(1'b0, 1'b0, 1'b0, 32'h44, '0, '0, '0);
    chk("R8 error cleared on next request", {31'b0, got_err}, 32'd0);
  endtask

  task automatic t_update;
    int b;
    do_req(1'b0, 1'b1, 1'b0, 32'h50, 32'hF0F0_1234, '0, '0);
    b = log_n;
    do_req(1'b0, 1'b0, 1'b1, 32'h50, '0, 32'hFFFF_00FF, 32'h0000_5A00);
    chk("R9 eight commands", log_n - b, 8);
    chk_entry("R9 read open", b, 8'h02, 32'd1);
    chk_entry("R9 read data", b + 2, 8'h07, 32'd0);
    chk_entry("R9 write open", b + 4, 8'h02, 32'd2);
    chk_entry("R9 write reg", b + 5, 8'h14, 32'h50);
    chk_entry("R9 merged data", b + 6, 8'h08, 32'hF0F0_5A34);
    chk("R9 target merged", mem_csr, 32'hF0F0_5A34);
    chk("R9 old value returned", got_rdata, 32'hF0F0_1234);
  endtask

  task automatic t_handshake;
    int b, guard;
    b = log_n;
    @(negedge clk);
    req_valid = 1'b1; req_mmio = 1'b0; req_write = 1'b0; req_update = 1'b0; req_addr = 32'h60;
    guard = 0;
    @(negedge clk);
    while (!rsp_done && guard < 30000) begin
      if (req_ready) begin
        checks++; fails++;
        $display("FAIL R10 ready high mid-transaction actual=1 expected=0");
      end
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    chk("R10 held valid gives one transaction", log_n - b, 4);
    @(negedge clk);
    chk("R10 done single pulse", {31'b0, rsp_done}, 32'd0);
    chk("R10 ready back", {31'b0, req_ready}, 32'd1);
    chk("R10 rdata held", rsp_rdata, 32'hF0F0_5A34);
    repeat (3) @(negedge clk);
    chk("R10 no second accept", log_n - b, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read_csr();
    t_write_mmio();
    t_busy_in_limit();
    t_busy_timeout();
    t_reject_retry();
    t_reject_all();
    t_update();
    t_handshake();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule